// File: doc/BRIEF.md
# Slow Clock Detector and Selector

This block produces the low-power reference tick that a baseband uses while its fast clock may be gated. It watches an optional external slow clock input from the 13 MHz reference domain. It brings the input through a synchronizer and measures the time between rising edges. Each period is classified as about 32 kHz, about 3.2 kHz, or no clock. A result is accepted only when two periods in a row agree, which keeps a single glitch or a lost edge from flipping the published result.

The tick comes from one of three sources. When a static configuration input says the 13 MHz clock runs all the time, the tick comes from an internal phase accumulator. Its average rate is exactly 32.768 kHz. When the fast clock may stop, the tick follows the rising edges of the external input, provided that input has been detected as a valid 32 kHz or 3.2 kHz clock. In every other case the tick follows the rising edges of the 32 kHz crystal input.

Top module: `lp_clk_select`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `det_code_o` is 2'b00, `det_valid_o` is 0 and `slow_tick_o` is 0.
- R2: An external input whose rising edges are 380 to 415 reference cycles apart, both ends included, is reported as code 2'b01 (about 32 kHz).
- R3: An external input whose rising edges are 3900 to 4250 reference cycles apart, both ends included, is reported as code 2'b10 (about 3.2 kHz).
- R4: A period outside both windows is classed as code 2'b00 (no clock). Codes 2'b00, 2'b01 and 2'b10 are the only values the code output takes.
- R5: If no rising edge arrives for 8192 reference cycles, that interval is classed as no clock. This repeats every 8192 cycles, so an input that stops makes the result 2'b00 after two such intervals.
- R6: `det_valid_o` rises only after two consecutive classifications agree. Once set, it stays set until reset.
- R7: The published code changes only when two consecutive classifications agree on the new class. A single differing period leaves the code unchanged.
- R8: When `ref_always_on_i` is 1, the ticks come from an accumulator that adds 32768 per reference cycle modulo 13,000,000. Successive ticks are therefore 396 or 397 cycles apart.
- R9: When `ref_always_on_i` is 0, `det_valid_o` is 1 and the code is 2'b01 or 2'b10, there is one tick per rising edge of `ext_lp_i`.
- R10: When `ref_always_on_i` is 0 and R9 does not apply, there is one tick per rising edge of `xtal_lp_i`.
- R11: While one source stays selected, every tick lasts exactly one reference cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 13 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_lp_i | input | 1 | Optional external slow clock, asynchronous |
| xtal_lp_i | input | 1 | 32 kHz crystal oscillator output, asynchronous |
| ref_always_on_i | input | 1 | Static configuration: 1 when the reference clock never stops |
| det_code_o | output | 2 | Detected class: 00 none, 01 about 32 kHz, 10 about 3.2 kHz |
| det_valid_o | output | 1 | Detection result is valid |
| slow_tick_o | output | 1 | Single-cycle low-power reference tick |

## Verification
The hardest situation to reach from the ports is a single stray period inside an otherwise steady clock, followed by a genuine change of class. The stimulus gets there by driving the external input one period at a time, so every edge-to-edge spacing is chosen exactly. A lone 4000-cycle period is placed between 397-cycle periods and must be ignored; two of them in a row must switch the code. Each window edge is swept on both sides, with periods such as 379/380 and 4250/4251. A stopped input is held long enough to pass through one timeout and then two.

// File: rtl/lpsel_pkg.sv
package lpsel_pkg;

    typedef enum logic [1:0] {
        LP_NONE = 2'b00,
        LP_F32K = 2'b01,
        LP_F3K2 = 2'b10
    } lp_class_e;

endpackage

// File: rtl/lpsel_edge_sync.sv
module lpsel_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES:0] chain;
        logic            rise;
    } st_t;

    st_t q, d;

    always_comb begin
        d       = q;
        d.chain = {q.chain[STAGES-1:0], async_i};
        d.rise  = q.chain[STAGES-1] & ~q.chain[STAGES];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rise_o = q.rise;

    // R11: an edge pulse never lasts two cycles
    a_r11_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.rise |=> !q.rise);

endmodule

// File: rtl/lpsel_period_meter.sv
module lpsel_period_meter
    import lpsel_pkg::*;
#(
    parameter int TIMEOUT     = 8192,
    parameter int FAST_MIN    = 380,
    parameter int FAST_MAX    = 415,
    parameter int SLOW_MIN    = 3900,
    parameter int SLOW_MAX    = 4250,
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lp_i,
    output logic      rise_o,
    output logic      meas_stb_o,
    output lp_class_e meas_cls_o
);

    localparam int CNT_W = $clog2(TIMEOUT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             stb;
        lp_class_e        cls;
    } st_t;

    st_t  q, d;
    logic rise;

    lpsel_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (lp_i),
        .rise_o  (rise)
    );

    function automatic lp_class_e classify(input logic [CNT_W-1:0] per);
        int v;
        v = int'(per);
        if (v >= FAST_MIN && v <= FAST_MAX)      return LP_F32K;
        else if (v >= SLOW_MIN && v <= SLOW_MAX) return LP_F3K2;
        else                                     return LP_NONE;
    endfunction

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        d.cls = LP_NONE;
        if (rise) begin
            d.stb   = q.armed;
            d.cls   = q.armed ? classify(q.cnt) : LP_NONE;
            d.cnt   = CNT_W'(1);
            d.armed = 1'b1;
        end else if (q.cnt >= CNT_W'(TIMEOUT)) begin
            d.stb   = 1'b1;
            d.cls   = LP_NONE;
            d.cnt   = CNT_W'(1);
            d.armed = 1'b0;
        end else begin
            d.cnt   = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{cnt: CNT_W'(1), armed: 1'b0, stb: 1'b0, cls: LP_NONE};
        else        q <= d;
    end

    assign rise_o     = rise;
    assign meas_stb_o = q.stb;
    assign meas_cls_o = q.cls;

    // R5: the period counter never runs past the timeout
    a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(TIMEOUT));

    // R4: measurement strobes are isolated single cycles
    a_r4_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.stb |=> !q.stb);

endmodule

// File: rtl/lpsel_class_filter.sv
module lpsel_class_filter
    import lpsel_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_stb_i,
    input  lp_class_e in_cls_i,
    output lp_class_e code_o,
    output logic      valid_o
);

    typedef struct packed {
        lp_class_e last;
        logic      have_last;
        lp_class_e code;
        logic      valid;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        if (in_stb_i) begin
            if (q.have_last && (in_cls_i == q.last)) begin
                d.code  = in_cls_i;
                d.valid = 1'b1;
            end
            d.last      = in_cls_i;
            d.have_last = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{last: LP_NONE, have_last: 1'b0, code: LP_NONE, valid: 1'b0};
        else        q <= d;
    end

    assign code_o  = q.code;
    assign valid_o = q.valid;

    // R6: valid is sticky once set
    a_r6_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |=> q.valid);

    // R6: valid only rises right after a measurement
    a_r6_valid_after_meas: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.valid) |-> $past(in_stb_i));

    // R7: code holds while no measurement arrives
    a_r7_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_stb_i |=> $stable(q.code));

endmodule

// File: rtl/lpsel_phase_nco.sv
module lpsel_phase_nco #(
    parameter int REF_HZ  = 13_000_000,
    parameter int TICK_HZ = 32_768
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    localparam int             ACC_W = $clog2(REF_HZ);
    localparam logic [ACC_W:0] STEP  = (ACC_W+1)'(TICK_HZ);
    localparam logic [ACC_W:0] WRAP  = (ACC_W+1)'(REF_HZ);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             tick;
    } st_t;

    st_t            q, d;
    logic [ACC_W:0] sum;

    always_comb begin
        d      = q;
        sum    = {1'b0, q.acc} + STEP;
        d.tick = 1'b0;
        if (sum >= WRAP) begin
            d.acc  = ACC_W'(sum - WRAP);
            d.tick = 1'b1;
        end else begin
            d.acc  = sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick_o = q.tick;

    // R8: phase stays inside its modulus
    a_r8_acc_range: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, q.acc} < WRAP);

    // R11: derived tick is a single cycle
    a_r11_nco_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.tick |=> !q.tick);

endmodule

// File: rtl/lp_clk_select.sv
module lp_clk_select
    import lpsel_pkg::*;
#(
    parameter int REF_HZ      = 13_000_000,
    parameter int TICK_HZ     = 32_768,
    parameter int TIMEOUT     = 8192,
    parameter int FAST_MIN    = 380,
    parameter int FAST_MAX    = 415,
    parameter int SLOW_MIN    = 3900,
    parameter int SLOW_MAX    = 4250,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_lp_i,
    input  logic       xtal_lp_i,
    input  logic       ref_always_on_i,
    output logic [1:0] det_code_o,
    output logic       det_valid_o,
    output logic       slow_tick_o
);

    typedef struct packed {
        logic tick;
    } st_t;

    st_t       q, d;
    logic      ext_rise, xtal_rise, nco_tick, meas_stb, ext_ok;
    lp_class_e meas_cls, code;
    logic      valid;

    lpsel_period_meter #(
        .TIMEOUT(TIMEOUT), .FAST_MIN(FAST_MIN), .FAST_MAX(FAST_MAX),
        .SLOW_MIN(SLOW_MIN), .SLOW_MAX(SLOW_MAX), .SYNC_STAGES(SYNC_STAGES)
    ) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .lp_i       (ext_lp_i),
        .rise_o     (ext_rise),
        .meas_stb_o (meas_stb),
        .meas_cls_o (meas_cls)
    );

    lpsel_class_filter u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_stb_i (meas_stb),
        .in_cls_i (meas_cls),
        .code_o   (code),
        .valid_o  (valid)
    );

    lpsel_edge_sync #(.STAGES(SYNC_STAGES)) u_xtal_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (xtal_lp_i),
        .rise_o  (xtal_rise)
    );

    lpsel_phase_nco #(.REF_HZ(REF_HZ), .TICK_HZ(TICK_HZ)) u_nco (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (nco_tick)
    );

    assign ext_ok = valid && (code != LP_NONE);

    always_comb begin
        d = q;
        if (ref_always_on_i) d.tick = nco_tick;
        else if (ext_ok)     d.tick = ext_rise;
        else                 d.tick = xtal_rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign det_code_o  = code;
    assign det_valid_o = valid;
    assign slow_tick_o = q.tick;

    // R4: the reserved code never appears
    a_r4_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        det_code_o != 2'b11);

    // R9: in external mode a tick always follows an external edge
    a_r9_ext_tick_src: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_always_on_i && ext_ok && $stable(ext_ok) && ext_rise) |=> slow_tick_o);

endmodule

// File: tb/lp_clk_select_test.sv
`timescale 1ns/1ps
module lp_clk_select_test;

    localparam int CLK_PERIOD = 76;
    localparam int WATCHDOG   = 195000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_lp = 1'b0;
    logic       xtal_lp = 1'b0;
    logic       always_on = 1'b0;
    logic [1:0] code;
    logic       valid;
    logic       tick;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int  tick_cnt = 0;
    int  xtal_rises = 0;
    bit  xtal_en = 1'b0;
    int  xtal_half = 200;
    bit  mon_nco = 1'b0;
    int  nco_bad = 0;
    int  last_tick = -1;
    bit  mon_single = 1'b0;
    int  single_bad = 0;
    bit  prev_tick = 1'b0;

    lp_clk_select uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .ext_lp_i        (ext_lp),
        .xtal_lp_i       (xtal_lp),
        .ref_always_on_i (always_on),
        .det_code_o      (code),
        .det_valid_o     (valid),
        .slow_tick_o     (tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitors sample at the falling edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (tick) tick_cnt <= tick_cnt + 1;
        if (mon_single && tick && prev_tick) single_bad <= single_bad + 1;
        prev_tick <= tick;
        if (mon_nco && tick) begin
            if (last_tick >= 0 && (cyc - last_tick != 396) && (cyc - last_tick != 397))
                nco_bad <= nco_bad + 1;
            last_tick <= cyc;
        end
        if (cyc > WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // crystal source
    initial begin
        forever begin
            @(negedge clk);
            if (xtal_en) begin
                repeat (xtal_half - 1) @(negedge clk);
                xtal_lp = ~xtal_lp;
                if (xtal_lp) xtal_rises = xtal_rises + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        ext_lp = 1'b0;
        wait_cyc(5);
        rst_n = 1'b1;
    endtask

    // one external period of p cycles, starting with a rising edge
    task automatic gen(input int p);
        ext_lp = 1'b1;
        wait_cyc(p / 2);
        ext_lp = 1'b0;
        wait_cyc(p - p / 2);
    endtask

    function automatic int class_of(input int p);
        if (p >= 380 && p <= 415)   return 1;
        if (p >= 3900 && p <= 4250) return 2;
        return 0;
    endfunction

    initial begin
        int t0;
        int x0;
        int sweep[10] = '{379, 380, 397, 415, 416, 3899, 3900, 4063, 4250, 4251};

        // R1: reset state
        rst_n = 1'b0;
        wait_cyc(4);
        chk(code == 2'b00, "R1 code in reset", int'(code), 0);
        chk(valid == 1'b0, "R1 valid in reset", int'(valid), 0);
        chk(tick == 1'b0, "R1 tick in reset", int'(tick), 0);
        rst_n = 1'b1;
        wait_cyc(1);
        chk(code == 2'b00 && valid == 1'b0 && tick == 1'b0, "R1 first cycle after reset",
            {code, valid, tick}, 0);

        // R5/R6/R10: no external clock, crystal running
        xtal_half = 200;
        xtal_en = 1'b1;
        wait_cyc(8300);
        chk(valid == 1'b0, "R6 one timeout is not enough", int'(valid), 0);
        t0 = tick_cnt;
        x0 = xtal_rises;
        wait_cyc(4000);
        chk((tick_cnt - t0) - (xtal_rises - x0) <= 1 && (xtal_rises - x0) - (tick_cnt - t0) <= 1,
            "R10 ticks follow crystal", tick_cnt - t0, xtal_rises - x0);
        wait_cyc(4200);
        chk(valid == 1'b1 && code == 2'b00, "R5 two timeouts give none", {code, valid}, 1);

        // R6: two agreeing periods needed
        do_reset();
        gen(397);
        gen(397);
        wait_cyc(10);
        chk(valid == 1'b0, "R6 one measurement only", int'(valid), 0);
        gen(397);
        wait_cyc(10);
        chk(valid == 1'b1 && code == 2'b01, "R6 valid after two agreeing", {code, valid}, 3);

        // R2/R3/R4: window edges
        foreach (sweep[i]) begin
            do_reset();
            gen(sweep[i]);
            gen(sweep[i]);
            gen(sweep[i]);
            wait_cyc(10);
            chk(valid == 1'b1 && int'(code) == class_of(sweep[i]),
                class_of(sweep[i]) == 1 ? "R2 window" : (class_of(sweep[i]) == 2 ? "R3 window" : "R4 outside"),
                int'(code), class_of(sweep[i]));
        end

        // R9: external 32 kHz source drives tick while crystal runs faster
        do_reset();
        xtal_half = 150;
        gen(397);
        gen(397);
        gen(397);
        wait_cyc(10);
        t0 = tick_cnt;
        mon_single = 1'b1;
        for (int k = 0; k < 10; k++) gen(397);
        chk(tick_cnt - t0 == 10, "R9 one tick per external edge", tick_cnt - t0, 10);
        chk(single_bad == 0, "R11 single-cycle ext ticks", single_bad, 0);
        mon_single = 1'b0;

        // R7: single stray period is ignored, two switch the code
        gen(4000);
        gen(397);
        gen(397);
        wait_cyc(10);
        chk(code == 2'b01, "R7 stray period ignored", int'(code), 1);
        gen(4000);
        gen(4000);
        gen(397);
        wait_cyc(10);
        chk(code == 2'b10, "R7 switch after two agreeing", int'(code), 2);

        // R5: external input stops
        ext_lp = 1'b0;
        wait_cyc(7000);
        chk(code == 2'b10, "R5 code held through first timeout", int'(code), 2);
        wait_cyc(10000);
        chk(code == 2'b00 && valid == 1'b1, "R5 stopped input becomes none", int'(code), 0);

        // R8/R11: derived tick from the reference
        always_on = 1'b1;
        do_reset();
        wait_cyc(5);
        t0 = tick_cnt;
        mon_nco = 1'b1;
        mon_single = 1'b1;
        wait_cyc(20000);
        mon_nco = 1'b0;
        mon_single = 1'b0;
        chk(nco_bad == 0, "R8 tick spacing 396 or 397", nco_bad, 0);
        chk(tick_cnt - t0 >= 50 && tick_cnt - t0 <= 51, "R8 tick count over 20000",
            tick_cnt - t0, 50);
        chk(single_bad == 0, "R11 single-cycle derived ticks", single_bad, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule